// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the general registers and status words of a 32-bit processor core with six privilege modes. Sixteen logical register numbers come in on two read ports and one write port. A mapping stage turns each number into a physical storage slot. The slot depends on the number and on the mode held in the current status word. Low registers are common to every mode. A fast-interrupt mode gets its own copies of the upper middle registers. Every exception mode gets its own stack pointer and link register. The program counter slot is a single register used by all modes.

The block also holds the current status word and one saved status word for each exception mode. An exception-entry strobe saves the current word into the target mode's saved word and switches mode in the same cycle. A return strobe restores the current word from the saved one. Two interrupt request inputs leave the block as pending outputs. Each is gated by its mask bit in the current status word.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads zero, every saved status word is zero, and the current status word is 0x000000D3 (Supervisor mode, I and F set).
- R2: Logical registers 0 to 7 select the same storage in every mode.
- R3: Logical registers 8 to 12 select private copies only in fast-interrupt mode (mode field 10001). Every other mode selects the common copies.
- R4: Logical registers 13 and 14 select a private pair in each exception mode: fast-interrupt 10001, normal-interrupt 10010, supervisor 10011, abort 10111, undefined 11011. User mode 10000 selects the user pair.
- R5: Logical register 15 selects one storage slot in every mode.
- R6: Reads are combinational from stored state. A write lands on the clock edge, so a read of the same register in the same cycle returns the old value and the new value appears after the edge.
- R7: The status word has N at bit 31, Z 30, C 29, V 28, Q 27, J 24, I 7, F 6, T 5 and the mode in bits 4:0. An exception entry to an exception mode saves the status word into that mode's saved word. In the same edge it writes the target into the mode field, sets I, and sets F only for fast-interrupt. An entry whose target is not an exception mode has no effect.
- R8: A return strobe copies the current mode's saved word into the status word. In user mode it has no effect.
- R9: A status write replaces the whole status word. Exception entry takes priority over return, and return takes priority over status writes and saved-word writes issued in the same cycle.
- R10: The saved-word read port shows the current mode's saved word, or zero in user mode. A saved-word write updates only the current mode's saved word and is ignored in user mode.
- R11: irq_pending is irq_req gated by I clear (bit 7). fiq_pending is fiq_req gated by F clear (bit 6).
- R12: A mode field value that is not one of the six encodings banks exactly like user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | 32 | Register write data |
| psr_wr_en | input | 1 | Current status word write enable |
| psr_wr_data | input | 32 | Current status word write data |
| psr_rd_data | output | 32 | Current status word |
| saved_wr_en | input | 1 | Saved status word write enable (current mode) |
| saved_wr_data | input | 32 | Saved status word write data |
| saved_rd_data | output | 32 | Saved status word of the current mode |
| exc_enter | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the exception entry |
| exc_return | input | 1 | Return strobe |
| irq_req | input | 1 | Normal interrupt request in |
| fiq_req | input | 1 | Fast interrupt request in |
| irq_pending | output | 1 | Masked normal interrupt request |
| fiq_pending | output | 1 | Masked fast interrupt request |

## Verification
Read data, the saved-word read and both pending outputs follow the stored state through combinational logic only. They are checked a nanosecond after inputs change in the low clock phase, with no edge in between. Register writes, status writes, entries and returns take effect on the next rising edge. Each is driven in the low phase, one rising edge is passed, and the result is read in the following low phase. The same-cycle hazard of R6 is checked on both sides of that one edge.

// File: rtl/bregs_pkg.sv
`timescale 1ns/1ps
package bregs_pkg;

    localparam int MODE_W = 5;
    localparam int IDX_W  = 4;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    localparam int BIT_I = 7;
    localparam int BIT_F = 6;

    // bank numbering decides where each mode's sp/lr pair sits
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int NBANKS      = 6;
    localparam int SHARED_LO   = 8;                   // r0..r7
    localparam int MID_N       = 5;                   // r8..r12
    localparam int USR_MID     = SHARED_LO;           // user copies of r8..r12
    localparam int FIQ_MID     = USR_MID + MID_N;     // fast copies of r8..r12
    localparam int PAIR_BASE   = FIQ_MID + MID_N;     // sp/lr pairs, two per bank
    localparam int PC_SLOT     = PAIR_BASE + 2 * NBANKS;
    localparam int PHYS_N      = PC_SLOT + 1;
    localparam int PHYS_W      = $clog2(PHYS_N);

    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bregs_bank_map.sv
`timescale 1ns/1ps
module bregs_bank_map
    import bregs_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  bank_e             bank,
    output logic [PHYS_W-1:0] phys
);

    logic [PHYS_W-1:0] idx_w;
    logic [PHYS_W-1:0] mid_off;
    logic [PHYS_W-1:0] pair_off;

    always_comb begin
        idx_w    = PHYS_W'(idx);
        mid_off  = idx_w - PHYS_W'(SHARED_LO);
        pair_off = PHYS_W'(int'(bank) * 2) + idx_w - PHYS_W'(13);
        if (idx_w < PHYS_W'(SHARED_LO)) begin
            phys = idx_w;
        end else if (idx_w < PHYS_W'(SHARED_LO + MID_N)) begin
            phys = (bank == BK_FIQ) ? PHYS_W'(FIQ_MID) + mid_off
                                    : PHYS_W'(USR_MID) + mid_off;
        end else if (idx_w < PHYS_W'(15)) begin
            phys = PHYS_W'(PAIR_BASE) + pair_off;
        end else begin
            phys = PHYS_W'(PC_SLOT);
        end
    end

endmodule

// File: rtl/bregs_psr.sv
`timescale 1ns/1ps
module bregs_psr
    import bregs_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psr_wr_en,
    input  logic [DATA_W-1:0]   psr_wr_data,
    input  logic                saved_wr_en,
    input  logic [DATA_W-1:0]   saved_wr_data,
    input  logic                exc_enter,
    input  logic [MODE_W-1:0]   exc_mode,
    input  logic                exc_return,
    output logic [DATA_W-1:0]   psr_o,
    output logic [DATA_W-1:0]   saved_o,
    output bank_e               cur_bank_o
);

    localparam logic [DATA_W-1:0] PSR_RST = DATA_W'({2'b11, 1'b0, MODE_SVC});

    typedef struct packed {
        logic [DATA_W-1:0]             cur;
        logic [NBANKS-1:0][DATA_W-1:0] saved;
    } psr_state_t;

    psr_state_t state_d, state_q;
    bank_e      tgt_bank, cur_bank;
    logic       enter_ok;

    always_comb begin
        state_d  = state_q;
        tgt_bank = mode_to_bank(exc_mode);
        cur_bank = mode_to_bank(state_q.cur[MODE_W-1:0]);
        enter_ok = exc_enter && (tgt_bank != BK_USR);
        if (enter_ok) begin
            state_d.saved[tgt_bank]     = state_q.cur;
            state_d.cur[MODE_W-1:0]     = exc_mode;
            state_d.cur[BIT_I]          = 1'b1;
            if (tgt_bank == BK_FIQ) begin
                state_d.cur[BIT_F]      = 1'b1;
            end
        end else if (exc_return && (cur_bank != BK_USR)) begin
            state_d.cur = state_q.saved[cur_bank];
        end else begin
            if (psr_wr_en) begin
                state_d.cur = psr_wr_data;
            end
            if (saved_wr_en && (cur_bank != BK_USR)) begin
                state_d.saved[cur_bank] = saved_wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cur   <= PSR_RST;
            state_q.saved <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign psr_o      = state_q.cur;
    assign cur_bank_o = cur_bank;
    assign saved_o    = (cur_bank == BK_USR) ? '0 : state_q.saved[cur_bank];

    a_r7_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        enter_ok |=> (psr_o[MODE_W-1:0] == $past(exc_mode)) && psr_o[BIT_I]);

    a_r7_enter_saves_word: assert property (@(posedge clk) disable iff (!rst_n)
        enter_ok |=> state_q.saved[$past(tgt_bank)] == $past(psr_o));

    a_r8_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !enter_ok && (cur_bank != BK_USR)) |=> psr_o == $past(saved_o));

    a_r10_user_saved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank == BK_USR) |-> (saved_o == '0));

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import bregs_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              psr_wr_en,
    input  logic [DATA_W-1:0] psr_wr_data,
    output logic [DATA_W-1:0] psr_rd_data,
    input  logic              saved_wr_en,
    input  logic [DATA_W-1:0] saved_wr_data,
    output logic [DATA_W-1:0] saved_rd_data,
    input  logic              exc_enter,
    input  logic [4:0]        exc_mode,
    input  logic              exc_return,
    input  logic              irq_req,
    input  logic              fiq_req,
    output logic              irq_pending,
    output logic              fiq_pending
);

    localparam int NPORTS = 3;   // read A, read B, write

    typedef struct packed {
        logic [PHYS_N-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t         rf_d, rf_q;
    bank_e             cur_bank;
    logic [IDX_W-1:0]  port_idx  [NPORTS];
    logic [PHYS_W-1:0] port_phys [NPORTS];

    bregs_psr #(.DATA_W(DATA_W)) u_psr (
        .clk           (clk),
        .rst_n         (rst_n),
        .psr_wr_en     (psr_wr_en),
        .psr_wr_data   (psr_wr_data),
        .saved_wr_en   (saved_wr_en),
        .saved_wr_data (saved_wr_data),
        .exc_enter     (exc_enter),
        .exc_mode      (exc_mode),
        .exc_return    (exc_return),
        .psr_o         (psr_rd_data),
        .saved_o       (saved_rd_data),
        .cur_bank_o    (cur_bank)
    );

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        bregs_bank_map u_map (
            .idx  (port_idx[p]),
            .bank (cur_bank),
            .phys (port_phys[p])
        );
    end

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            rf_d.regs[port_phys[2]] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_a_data   = rf_q.regs[port_phys[0]];
    assign rd_b_data   = rf_q.regs[port_phys[1]];
    assign irq_pending = irq_req & ~psr_rd_data[BIT_I];
    assign fiq_pending = fiq_req & ~psr_rd_data[BIT_F];

    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rf_q.regs[$past(port_phys[2])] == $past(wr_data));

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        psr_rd_data[BIT_I] |-> !irq_pending);

    a_r11_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        psr_rd_data[BIT_F] |-> !fiq_pending);

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, psr_wr_en, saved_wr_en, exc_enter, exc_return;
    logic [31:0] psr_wr_data, psr_rd_data, saved_wr_data, saved_rd_data;
    logic [4:0]  exc_mode;
    logic        irq_req, fiq_req, irq_pending, fiq_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_rd_data(psr_rd_data),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_rd_data(saved_rd_data),
        .exc_enter(exc_enter), .exc_mode(exc_mode), .exc_return(exc_return),
        .irq_req(irq_req), .fiq_req(fiq_req),
        .irq_pending(irq_pending), .fiq_pending(fiq_pending)
    );

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010;
    localparam logic [4:0] SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011;

    typedef struct packed {
        logic        is_wr;
        logic [4:0]  mode;
        logic [3:0]  idx;
        logic [31:0] data;   // write value or expected read value
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 27;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, USR, 4'd3,  32'h0000_0033, 8'd2},
        '{1'b1, USR, 4'd8,  32'h0000_1008, 8'd3},
        '{1'b1, FIQ, 4'd8,  32'h0000_F008, 8'd3},
        '{1'b1, USR, 4'd13, 32'h0000_1013, 8'd4},
        '{1'b1, FIQ, 4'd13, 32'h0000_F013, 8'd4},
        '{1'b1, IRQ, 4'd13, 32'h0000_2013, 8'd4},
        '{1'b1, SVC, 4'd14, 32'h0000_3014, 8'd4},
        '{1'b1, ABT, 4'd14, 32'h0000_7014, 8'd4},
        '{1'b1, UND, 4'd14, 32'h0000_B014, 8'd4},
        '{1'b1, FIQ, 4'd15, 32'h0000_F015, 8'd5},
        '{1'b1, IRQ, 4'd12, 32'h0000_2012, 8'd3},
        '{1'b0, IRQ, 4'd3,  32'h0000_0033, 8'd2},  // R2
        '{1'b0, FIQ, 4'd3,  32'h0000_0033, 8'd2},  // R2
        '{1'b0, SVC, 4'd8,  32'h0000_1008, 8'd3},  // R3
        '{1'b0, FIQ, 4'd8,  32'h0000_F008, 8'd3},  // R3
        '{1'b0, USR, 4'd12, 32'h0000_2012, 8'd3},  // R3
        '{1'b0, FIQ, 4'd12, 32'h0000_0000, 8'd3},  // R3
        '{1'b0, USR, 4'd13, 32'h0000_1013, 8'd4},  // R4
        '{1'b0, FIQ, 4'd13, 32'h0000_F013, 8'd4},  // R4
        '{1'b0, IRQ, 4'd13, 32'h0000_2013, 8'd4},  // R4
        '{1'b0, SVC, 4'd13, 32'h0000_0000, 8'd4},  // R4
        '{1'b0, ABT, 4'd14, 32'h0000_7014, 8'd4},  // R4
        '{1'b0, UND, 4'd14, 32'h0000_B014, 8'd4},  // R4
        '{1'b0, SVC, 4'd14, 32'h0000_3014, 8'd4},  // R4
        '{1'b0, USR, 4'd15, 32'h0000_F015, 8'd5},  // R5
        '{1'b0, 5'b11111, 4'd13, 32'h0000_1013, 8'd12},  // R12
        '{1'b0, 5'b00000, 4'd8,  32'h0000_1008, 8'd12}   // R12
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one rising edge, then strobes cleared in the low phase
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; psr_wr_en = 1'b0; saved_wr_en = 1'b0;
        exc_enter = 1'b0; exc_return = 1'b0;
    endtask

    task automatic write_psr(input logic [31:0] v);
        psr_wr_en = 1'b1; psr_wr_data = v;
        tick();
    endtask

    task automatic set_mode(input logic [4:0] m);
        write_psr({24'h0, 3'b110, m});
    endtask

    task automatic read_both(input logic [3:0] idx, input logic [31:0] exp, input string tag);
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
        chk({tag, " port A"}, rd_a_data, exp);
        chk({tag, " port B"}, rd_b_data, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; wr_en = 1'b0;
        psr_wr_en = 1'b0; psr_wr_data = '0; saved_wr_en = 1'b0; saved_wr_data = '0;
        exc_enter = 1'b0; exc_mode = '0; exc_return = 1'b0;
        irq_req = 1'b1; fiq_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state, R11 masks both requests with I and F set
        chk("R1 status word", psr_rd_data, 32'h0000_00D3);
        chk("R1 saved word", saved_rd_data, 32'h0);
        read_both(4'd0, 32'h0, "R1 r0");
        read_both(4'd13, 32'h0, "R1 r13");
        chk("R11 irq masked at reset", {31'h0, irq_pending}, 32'h0);
        chk("R11 fiq masked at reset", {31'h0, fiq_pending}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            set_mode(VECS[i].mode);
            if (VECS[i].is_wr) begin
                wr_en = 1'b1; wr_idx = VECS[i].idx; wr_data = VECS[i].data;
                tick();
            end else begin
                read_both(VECS[i].idx, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
            end
        end

        // R6 same-cycle write/read of one register
        set_mode(USR);
        rd_a_idx = 4'd5; rd_b_idx = 4'd5;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0000_AAAA;
        #1;
        chk("R6 old value before edge", rd_a_data, 32'h0);
        tick();
        #1;
        chk("R6 new value after edge", rd_a_data, 32'h0000_AAAA);

        // R7 entry to normal-interrupt mode from user with flags set
        write_psr(32'hF000_0010);
        exc_enter = 1'b1; exc_mode = IRQ;
        tick();
        #1;
        chk("R7 irq entry status", psr_rd_data, 32'hF000_0092);
        chk("R7 irq entry saved", saved_rd_data, 32'hF000_0010);
        read_both(4'd13, 32'h0000_2013, "R4 r13 after entry");

        // R8 return restores, then return in user is ignored
        exc_return = 1'b1;
        tick();
        #1;
        chk("R8 return status", psr_rd_data, 32'hF000_0010);
        exc_return = 1'b1;
        tick();
        #1;
        chk("R8 user return ignored", psr_rd_data, 32'hF000_0010);

        // R7 entry with a non-exception target is ignored
        exc_enter = 1'b1; exc_mode = USR;
        tick();
        #1;
        chk("R7 invalid target ignored", psr_rd_data, 32'hF000_0010);

        // R9 entry wins over a status write in the same cycle; R7 sets F for fast
        exc_enter = 1'b1; exc_mode = FIQ;
        psr_wr_en = 1'b1; psr_wr_data = 32'h0000_001F;
        tick();
        #1;
        chk("R9 entry beats status write", psr_rd_data, 32'hF000_00D1);
        chk("R7 fiq entry saved", saved_rd_data, 32'hF000_0010);
        read_both(4'd8, 32'h0000_F008, "R3 r8 after fiq entry");

        // R10 saved-word writes per mode
        saved_wr_en = 1'b1; saved_wr_data = 32'h0000_1234;
        tick();
        #1;
        chk("R10 saved write in fiq", saved_rd_data, 32'h0000_1234);
        set_mode(ABT);
        #1;
        chk("R10 abort saved untouched", saved_rd_data, 32'h0);
        set_mode(USR);
        saved_wr_en = 1'b1; saved_wr_data = 32'h0000_5555;
        tick();
        #1;
        chk("R10 user saved reads zero", saved_rd_data, 32'h0);
        set_mode(FIQ);
        #1;
        chk("R10 user write ignored", saved_rd_data, 32'h0000_1234);

        // R11 request masking by I (bit 7) and F (bit 6)
        write_psr(32'h0000_0011);
        #1;
        chk("R11 irq open", {31'h0, irq_pending}, 32'h1);
        chk("R11 fiq open", {31'h0, fiq_pending}, 32'h1);
        write_psr(32'h0000_0051);
        #1;
        chk("R11 fiq masked by F", {31'h0, fiq_pending}, 32'h0);
        chk("R11 irq open with F", {31'h0, irq_pending}, 32'h1);
        write_psr(32'h0000_0091);
        #1;
        chk("R11 irq masked by I", {31'h0, irq_pending}, 32'h0);
        chk("R11 fiq open with I", {31'h0, fiq_pending}, 32'h1);
        irq_req = 1'b0;
        write_psr(32'h0000_0011);
        #1;
        chk("R11 no request no pending", {31'h0, irq_pending}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule